// File: doc/BRIEF.md
# Power-Management Event and Timer Block

This block keeps the event side of a power-management controller. It holds a 16-bit event status register and a 16-bit event enable register, and it runs a free-running power-management tick counter. All three can be read over a small byte-addressed register port. Status bits are raised by the tick counter when it passes a boundary, by a power-button request, and by wake-cause inputs. Software clears them by writing ones.

The block drives a level-sensitive system-control interrupt. The interrupt stays high while any enabled event in the common-event group is pending, or while an external general-purpose-event request is high. The counter advances once per cycle in which the tick-enable input is high. That input stands for a 3.579545 MHz time base generated elsewhere.

Top module: `pm_event_block`

## Requirements
- R1: Reads are combinational on `regRdData`. Offset 0 returns the 16-bit status and offset 1 returns its upper byte. Offset 2 returns the 16-bit enable and offset 3 returns its upper byte. Offsets 8 to 11 return the tick count zero-extended to 32 bits, shifted right by 8 bits for each byte past offset 8. Every other offset reads 0.
- R2: A status write clears each bit written as 1 and leaves bits written as 0 unchanged. A halfword write (`regWrHalf`=1) at offset 0 covers all 16 bits. A byte write at offset 0 or 1 takes `regWrData[7:0]` into the low or high byte. A halfword write at an odd offset has no effect.
- R3: An enable write stores the written bits. A halfword write goes to offset 2. A byte write at offset 2 or 3 takes `regWrData[7:0]` into the low or high byte.
- R4: The tick count rises by one on each clock in which `tickEn` is 1. It wraps modulo 2^TIMER_W. Writes at offsets 8 to 11 do not change it.
- R5: Timer status (bit 0) is set on the clock edge after the count equals the armed boundary. Reset arms the boundary at 0, so bit 0 is set on the first edge after reset release.
- R6: A write that clears bit 0 while bit 0 is set re-arms the boundary. The new boundary is the current count plus 2^OVF_BIT, rounded down to a multiple of 2^OVF_BIT, modulo 2^TIMER_W.
- R7: A power-button request sets power-button status (bit 8) only while enable bit 8 is 1.
- R8: The three wake inputs each set wake status (bit 15) together with a cause bit. An RTC wake adds bit 10, a timer wake adds bit 0, and any other wake adds bit 8.
- R9: `sciOut` is high while status AND enable AND the common-event mask is nonzero. The mask covers bits 0, 5, 8 and 10, which gives 0x0521.
- R10: `sciOut` is high whenever `gpeReq` is high, whatever the status and enable.
- R11: Reset clears status, enable, the tick count and the armed boundary.
- R12: If a set source and a software clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Advances the tick counter |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWrEn | input | 1 | Write strobe |
| regWrHalf | input | 1 | 1 = halfword write, 0 = byte write |
| regWrData | input | 16 | Write data (bytes use bits 7:0) |
| regRdData | output | 32 | Read data for `regAddr` |
| pwrBtnReq | input | 1 | Power-button request |
| wakeRtc | input | 1 | Wake caused by the RTC |
| wakeTimer | input | 1 | Wake caused by the tick timer |
| wakeOther | input | 1 | Wake from any other cause |
| gpeReq | input | 1 | External general-purpose-event request |
| sciOut | output | 1 | System-control interrupt level |

## Verification
The bench builds the block with TIMER_W=8 and OVF_BIT=7, so boundaries fall every 128 ticks and the count wraps every 256. In a few hundred cycles this reaches the boundary crossing, the re-arm from a mid-period count, the re-arm that wraps to boundary 0, and the counter wrap. Each cycle it compares the interrupt level and the register read at the offset being driven against a behavioural model. That model covers a clear and a set landing together, and a clear of bit 0 issued while the count already sits on the armed boundary.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int STS_W = 16;

  // status / enable bit positions
  localparam int BIT_TMR    = 0;
  localparam int BIT_GBL    = 5;
  localparam int BIT_PWRBTN = 8;
  localparam int BIT_RTC    = 10;
  localparam int BIT_WAKE   = 15;

  localparam logic [STS_W-1:0] COMMON_MASK =
    (STS_W'(1) << BIT_TMR) | (STS_W'(1) << BIT_GBL) |
    (STS_W'(1) << BIT_PWRBTN) | (STS_W'(1) << BIT_RTC);

  // register offsets
  localparam int OFS_STS = 0;
  localparam int OFS_EN  = 2;
  localparam int OFS_TMR = 8;

  localparam int RD_W   = 32;
  localparam int LANES  = STS_W / 8;

  typedef struct packed {
    logic [STS_W-1:0] stsClr;
    logic [STS_W-1:0] enMask;
    logic [STS_W-1:0] enData;
  } pm_strobe_t;
endpackage

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int TIMER_W = 24
) (
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic               regWrHalf,
  input  logic [STS_W-1:0]   regWrData,
  input  logic [STS_W-1:0]   stsVal,
  input  logic [STS_W-1:0]   enVal,
  input  logic [TIMER_W-1:0] timerVal,
  output pm_strobe_t         strobe,
  output logic [RD_W-1:0]    regRdData
);
  localparam int TMR_BYTES = RD_W / 8;

  logic halfSts;
  logic halfEn;

  assign halfSts = regWrEn && regWrHalf && (regAddr == ADDR_W'(OFS_STS));
  assign halfEn  = regWrEn && regWrHalf && (regAddr == ADDR_W'(OFS_EN));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic byteSts;
    logic byteEn;
    assign byteSts = regWrEn && !regWrHalf && (regAddr == ADDR_W'(OFS_STS + l));
    assign byteEn  = regWrEn && !regWrHalf && (regAddr == ADDR_W'(OFS_EN + l));

    assign strobe.stsClr[8*l +: 8] = (halfSts ? regWrData[8*l +: 8] : 8'h00) |
                                     (byteSts ? regWrData[7:0]      : 8'h00);
    assign strobe.enMask[8*l +: 8] = {8{halfEn | byteEn}};
    assign strobe.enData[8*l +: 8] = halfEn ? regWrData[8*l +: 8] : regWrData[7:0];
  end

  logic [RD_W-1:0] tmrWide;
  assign tmrWide = RD_W'(timerVal);

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(OFS_STS)) begin
      regRdData = RD_W'(stsVal);
    end else if (regAddr == ADDR_W'(OFS_STS + 1)) begin
      regRdData = RD_W'(stsVal[STS_W-1:8]);
    end else if (regAddr == ADDR_W'(OFS_EN)) begin
      regRdData = RD_W'(enVal);
    end else if (regAddr == ADDR_W'(OFS_EN + 1)) begin
      regRdData = RD_W'(enVal[STS_W-1:8]);
    end else begin
      for (int b = 0; b < TMR_BYTES; b++) begin
        if (regAddr == ADDR_W'(OFS_TMR + b)) begin
          regRdData = tmrWide >> (8 * b);
        end
      end
    end
  end
endmodule

// File: rtl/pm_evt_datapath.sv
module pm_evt_datapath
  import pm_evt_pkg::*;
#(
  parameter int TIMER_W = 24,
  parameter int OVF_BIT = 23
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  pm_strobe_t         strobe,
  input  logic               pwrBtnReq,
  input  logic               wakeRtc,
  input  logic               wakeTimer,
  input  logic               wakeOther,
  input  logic               gpeReq,
  output logic [STS_W-1:0]   stsVal,
  output logic [STS_W-1:0]   enVal,
  output logic [TIMER_W-1:0] timerVal,
  output logic               sciOut
);
  localparam logic [TIMER_W-1:0] STEP_V  = TIMER_W'(1) << OVF_BIT;
  localparam logic [TIMER_W-1:0] ALIGN_M = ~(STEP_V - TIMER_W'(1));

  logic [TIMER_W-1:0] timerQ;
  logic [TIMER_W-1:0] boundaryQ;
  logic [STS_W-1:0]   stsQ;
  logic [STS_W-1:0]   enQ;
  logic [STS_W-1:0]   setVec;
  logic               hitBoundary;
  logic               rearm;
  logic [TIMER_W-1:0] rearmPoint;

  assign hitBoundary = (timerQ == boundaryQ);
  assign rearm       = strobe.stsClr[BIT_TMR] && stsQ[BIT_TMR];
  assign rearmPoint  = (timerQ + STEP_V) & ALIGN_M;

  // tick counter, wraps silently
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (tickEn) begin
      timerQ <= timerQ + TIMER_W'(1);
    end
  end

  // armed boundary
  always_ff @(posedge clk) begin
    if (!rstN) begin
      boundaryQ <= '0;
    end else if (rearm) begin
      boundaryQ <= rearmPoint;
    end
  end

  always_comb begin
    setVec = '0;
    setVec[BIT_TMR]    = hitBoundary | wakeTimer;
    setVec[BIT_PWRBTN] = (pwrBtnReq & enQ[BIT_PWRBTN]) | wakeOther;
    setVec[BIT_RTC]    = wakeRtc;
    setVec[BIT_WAKE]   = wakeRtc | wakeTimer | wakeOther;
  end

  // status bits: set wins over clear
  for (genvar i = 0; i < STS_W; i++) begin : g_sts
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stsQ[i] <= 1'b0;
      end else begin
        stsQ[i] <= (stsQ[i] & ~strobe.stsClr[i]) | setVec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= '0;
    end else begin
      enQ <= (enQ & ~strobe.enMask) | (strobe.enData & strobe.enMask);
    end
  end

  assign sciOut   = (|(stsQ & enQ & COMMON_MASK)) | gpeReq;
  assign stsVal   = stsQ;
  assign enVal    = enQ;
  assign timerVal = timerQ;
endmodule

// File: rtl/pm_event_block.sv
module pm_event_block
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int TIMER_W = 24,
  parameter int OVF_BIT = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regWrHalf,
  input  logic [15:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              pwrBtnReq,
  input  logic              wakeRtc,
  input  logic              wakeTimer,
  input  logic              wakeOther,
  input  logic              gpeReq,
  output logic              sciOut
);
  pm_strobe_t         strobe;
  logic [STS_W-1:0]   stsVal;
  logic [STS_W-1:0]   enVal;
  logic [TIMER_W-1:0] timerVal;

  pm_evt_ctrl #(.ADDR_W(ADDR_W), .TIMER_W(TIMER_W)) ctrl_i (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrHalf (regWrHalf),
    .regWrData (regWrData),
    .stsVal    (stsVal),
    .enVal     (enVal),
    .timerVal  (timerVal),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  pm_evt_datapath #(.TIMER_W(TIMER_W), .OVF_BIT(OVF_BIT)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .strobe    (strobe),
    .pwrBtnReq (pwrBtnReq),
    .wakeRtc   (wakeRtc),
    .wakeTimer (wakeTimer),
    .wakeOther (wakeOther),
    .gpeReq    (gpeReq),
    .stsVal    (stsVal),
    .enVal     (enVal),
    .timerVal  (timerVal),
    .sciOut    (sciOut)
  );
endmodule

// File: rtl/pm_evt_checker.sv
module pm_evt_checker #(
  parameter int ADDR_W  = 4,
  parameter int TIMER_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               tickEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic               regWrHalf,
  input logic [15:0]        regWrData,
  input logic               pwrBtnReq,
  input logic               wakeRtc,
  input logic               wakeTimer,
  input logic               wakeOther,
  input logic               gpeReq,
  input logic               sciOut,
  input logic [15:0]        stsVal,
  input logic [15:0]        enVal,
  input logic [TIMER_W-1:0] timerVal
);
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> timerVal == TIMER_W'($past(timerVal) + 1)); // R4
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(timerVal)); // R4
  AST_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrHalf && regAddr == ADDR_W'(0) && regWrData[10] && !wakeRtc)
      |=> !stsVal[10]); // R2
  AST_EN_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrHalf && regAddr == ADDR_W'(2)) |=> enVal == $past(regWrData)); // R3
  AST_PWRBTN_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (!stsVal[8] && pwrBtnReq && !enVal[8] && !wakeOther) |=> !stsVal[8]); // R7
  AST_RTC_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    wakeRtc |=> (stsVal[15] && stsVal[10])); // R8
  AST_TMR_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    wakeTimer |=> (stsVal[15] && stsVal[0])); // R8
  AST_GPE_SCI: assert property (@(posedge clk) disable iff (!rstN)
    gpeReq |-> sciOut); // R10
endmodule

bind pm_event_block pm_evt_checker #(.ADDR_W(ADDR_W), .TIMER_W(TIMER_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrHalf (regWrHalf),
  .regWrData (regWrData),
  .pwrBtnReq (pwrBtnReq),
  .wakeRtc   (wakeRtc),
  .wakeTimer (wakeTimer),
  .wakeOther (wakeOther),
  .gpeReq    (gpeReq),
  .sciOut    (sciOut),
  .stsVal    (stsVal),
  .enVal     (enVal),
  .timerVal  (timerVal)
);

// File: tb/pm_event_block_tb_top.sv
module pm_event_block_tb_top;
  localparam int TB_TIMER_W = 8;
  localparam int TB_OVF     = 7;
  localparam int TMASK      = (1 << TB_TIMER_W) - 1;
  localparam int STEP       = 1 << TB_OVF;
  localparam int MASK_COM   = 32'h0521;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regWrHalf = 1'b0;
  logic [15:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pwrBtnReq = 1'b0;
  logic        wakeRtc = 1'b0;
  logic        wakeTimer = 1'b0;
  logic        wakeOther = 1'b0;
  logic        gpeReq = 1'b0;
  logic        sciOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural model state
  int msts = 0;
  int men = 0;
  int mcount = 0;
  int mnext = 0;

  always #2.5ns clk = ~clk;

  pm_event_block #(.ADDR_W(4), .TIMER_W(TB_TIMER_W), .OVF_BIT(TB_OVF)) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrHalf(regWrHalf), .regWrData(regWrData),
    .regRdData(regRdData), .pwrBtnReq(pwrBtnReq), .wakeRtc(wakeRtc),
    .wakeTimer(wakeTimer), .wakeOther(wakeOther), .gpeReq(gpeReq),
    .sciOut(sciOut)
  );

  function automatic int rdExp(input int a);
    if (a == 0) return msts;
    if (a == 1) return msts >> 8;
    if (a == 2) return men;
    if (a == 3) return men >> 8;
    if (a >= 8 && a <= 11) return mcount >> (8 * (a - 8));
    return 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input int a, input bit we, input bit hf, input int d, input bit tk,
                     input bit pb, input bit rtc, input bit tw, input bit oth,
                     input bit gpe, input string tag);
    int clr, enM, enD, setm;
    regAddr = 4'(a); regWrEn = we; regWrHalf = hf; regWrData = 16'(d);
    tickEn = tk; pwrBtnReq = pb; wakeRtc = rtc; wakeTimer = tw;
    wakeOther = oth; gpeReq = gpe;
    #1ns;
    check(tag, "read", int'(regRdData), rdExp(a));
    check(tag, "sci", int'(sciOut), (((msts & men & MASK_COM) != 0) || gpe) ? 1 : 0);
    @(posedge clk);
    if (rstN) begin
      clr = 0; enM = 0; enD = 0; setm = 0;
      if (we) begin
        if (hf) begin
          if (a == 0) clr = d & 16'hFFFF;
          else if (a == 2) begin enM = 16'hFFFF; enD = d & 16'hFFFF; end
        end else begin
          if (a == 0) clr = d & 255;
          else if (a == 1) clr = (d & 255) << 8;
          else if (a == 2) begin enM = 255; enD = d & 255; end
          else if (a == 3) begin enM = 16'hFF00; enD = (d & 255) << 8; end
        end
      end
      if (mcount == mnext) setm |= 1;
      if (tw) setm |= 16'h8001;
      if (rtc) setm |= 16'h8400;
      if (oth) setm |= 16'h8100;
      if (pb && (men & 16'h0100) != 0) setm |= 16'h0100;
      if ((clr & 1) != 0 && (msts & 1) != 0) mnext = ((mcount + STEP) & ~(STEP - 1)) & TMASK;
      msts = ((msts & ~clr) | setm) & 16'hFFFF;
      men  = ((men & ~enM) | (enD & enM)) & 16'hFFFF;
      if (tk) mcount = (mcount + 1) & TMASK;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int a, input bit tk, input string tag);
    for (int i = 0; i < n; i++) cyc(a, 0, 0, 0, tk, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input int a, input bit hf, input int d, input string tag);
    cyc(a, 1, hf, d, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R11: reset state
    idle(2, 0, 1, "R11");
    idle(1, 2, 1, "R11");
    idle(1, 8, 1, "R11");
    rstN = 1'b1;
    // R5: boundary 0 armed at reset sets timer status
    idle(2, 0, 0, "R5");
    // R3 and R9: enable common events
    wr(2, 1, 16'h0521, "R3");
    idle(1, 2, 0, "R9");
    idle(1, 1, 0, "R1");
    // R4: count advances
    idle(5, 8, 1, "R4");
    // R6: clear timer status, boundary re-arms at 128
    wr(0, 1, 16'h0001, "R6");
    idle(130, 0, 1, "R5");
    idle(80, 8, 1, "R4");
    // R6: clear near top, re-arm wraps to 0
    wr(0, 1, 16'h0001, "R6");
    idle(60, 0, 1, "R6");
    idle(4, 9, 1, "R1");
    // R4: timer writes ignored
    wr(8, 1, 16'hFFFF, "R4");
    wr(9, 0, 16'h00FF, "R4");
    idle(1, 8, 0, "R4");
    // R2: misaligned halfword ignored, byte clear works
    wr(1, 1, 16'hFFFF, "R2");
    idle(1, 0, 0, "R2");
    wr(0, 0, 16'h0001, "R2");
    idle(1, 0, 0, "R2");
    // R7: power button gated by enable bit 8
    wr(2, 1, 16'h0021, "R3");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
    idle(1, 0, 0, "R7");
    wr(3, 0, 16'h0001, "R3");
    idle(1, 3, 0, "R3");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7");
    idle(1, 0, 0, "R9");
    // R8: wake causes
    wr(0, 1, 16'hFFFF, "R2");
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
    idle(1, 0, 0, "R8");
    wr(0, 1, 16'hFFFF, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R8");
    idle(1, 0, 0, "R8");
    wr(0, 1, 16'hFFFF, "R2");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    idle(1, 1, 0, "R8");
    // R12: set and clear together
    cyc(0, 1, 1, 16'h0400, 0, 0, 1, 0, 0, 0, "R12");
    idle(1, 0, 0, "R12");
    // R10: GPE request with nothing enabled
    wr(2, 1, 16'h0000, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
    idle(1, 0, 0, "R10");
    // R4: gapped ticking
    for (int i = 0; i < 40; i++) cyc(8, 0, 0, 0, (i % 3) != 0, 0, 0, 0, 0, 0, "R4");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule